// File: doc/BRIEF.md
# Micro-step Position Translator

This block keeps the electrical position of a two-phase bipolar stepper motor as a 6-bit count. One count is a sixteenth of a full step, so 64 counts make one electrical revolution. Each step trigger moves the count by the size the selected resolution gives. The move goes forward or backward according to the effective direction. A trigger is a rising edge on the step pin or a self-clearing command bit in the control register. From the position, the block decodes a sign and a quarter-wave table index for each coil. Coil Y follows the sine of the electrical angle and coil X the cosine. A current regulator downstream looks up its set points with these indices.

Settings arrive through a small parallel register port. Selector 0 addresses the control register, which holds the resolution, the direction polarity and the step command. Selector 1 addresses the position, which can be written directly. A sleep input blocks every trigger. When the resolution is lowered, the next trigger lands on the coarser grid. If the position is off that grid, it moves to the nearest grid point in the direction of travel.

Top module: `microstep_translator`

## Requirements
- R1: After reset the position is 8, the resolution code is 0 (1/16), the polarity is 0 and no command is pending. A control read then returns 0.
- R2: Resolution codes 0, 1, 2, 3 and 4 make a step 1, 2, 4, 8 and 16 counts, respectively. Codes 5 to 7 behave as code 4 (full step).
- R3: The effective direction is the direction pin XOR the polarity bit. When it is 1 the position increases, and when it is 0 it decreases. The position wraps modulo 64.
- R4: A step pin rising edge gives exactly one step, in the cycle it is seen, however long the pin then stays high. Writing 1 to the command bit gives one step in the cycle after the write. The bit then reads back 0.
- R5: Writing a new resolution or polarity leaves the position unchanged. The next trigger uses the new settings. A single control write may carry the resolution, polarity and command together, and the resulting step uses all three.
- R6: If the position is off the grid of the current resolution, a forward trigger moves it to the next grid point above. A backward trigger moves it to the grid point below.
- R7: A position write (selector 1, data bits 5:0) takes effect one cycle later, whatever the resolution. It takes priority over a trigger in the same cycle.
- R8: While sleep is 1, the position does not step. A pending command is discarded, and a command written during sleep is dropped.
- R9: Coil Y index is 16 − |(p mod 32) − 16| and its sign flag is 1 exactly when p > 32.
- R10: Coil X index is |(p mod 32) − 16|, and its sign flag is 1 exactly when 16 < p < 48. On positions 0, 16, 32 and 48 exactly one coil index is non-zero.
- R11: A pin edge in the same cycle as a command write gives two steps on consecutive cycles: the pin step first, then the command step.
- R12: Control layout: bits 2:0 resolution, bit 3 polarity, bit 4 command. A read with selector 0 returns {command pending, polarity, resolution} in bits 4:0. A read with selector 1 returns the position in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep | input | 1 | Blocks all step triggers while 1 |
| step_pin | input | 1 | Step input, rising edge triggers a step |
| dir_pin | input | 1 | Direction input |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 position |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for the selected register |
| pos | output | POS_W | Electrical position in 1/16-step counts |
| x_neg | output | 1 | Coil X current negative |
| x_idx | output | POS_W-1 | Coil X quarter-wave index, 0 to 16 |
| y_neg | output | 1 | Coil Y current negative |
| y_idx | output | POS_W-1 | Coil Y quarter-wave index, 0 to 16 |

## Verification
The bench builds the block with its default widths: a 6-bit position, a 3-bit resolution code and an 8-bit register port. With these values the 64-count wrap is reached in a few full steps in either direction. The reserved resolution codes are within reach, and so is snapping from off-grid positions such as 9 and 22. A sweep of position writes covers every quadrant of the coil decode. Directed cycles cover the same-cycle collision of a pin edge with a command write, and a command that is made pending and then cancelled by sleep.

// File: rtl/microstep_translator.sv
module microstep_translator #(
  parameter int POS_W  = 6,
  parameter int MODE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              step_pin,
  input  logic              dir_pin,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [POS_W-1:0]  pos,
  output logic              x_neg,
  output logic [POS_W-2:0]  x_idx,
  output logic              y_neg,
  output logic [POS_W-2:0]  y_idx
);
  localparam int QB      = POS_W - 2;
  localparam int QSPAN   = 1 << QB;
  localparam int CMD_BIT = MODE_W + 1;
  localparam logic [POS_W-1:0] HOME = POS_W'(QSPAN / 2);

  logic [MODE_W-1:0] mode_q;
  logic pol_q, cmd_q, pin_q;
  logic ctrl_wr, pos_wr, pin_edge, take_pin, take_cmd, trig, fwd;
  logic [POS_W-1:0] step_sz, grid_mask, base, next_pos, xp;

  assign ctrl_wr  = cfg_we & ~cfg_sel;
  assign pos_wr   = cfg_we & cfg_sel;
  assign pin_edge = step_pin & ~pin_q;
  assign take_pin = pin_edge & ~sleep & ~pos_wr;
  assign take_cmd = cmd_q & ~sleep & ~pos_wr & ~pin_edge;
  assign trig     = take_pin | take_cmd;
  assign fwd      = dir_pin ^ pol_q;

  always_comb begin
    step_sz = POS_W'(1) << QB;
    if (int'(mode_q) < QB) step_sz = POS_W'(1) << mode_q;
  end

  assign grid_mask = step_sz - POS_W'(1);
  assign base      = pos & ~grid_mask;
  assign next_pos  = fwd ? base + step_sz
                         : (((pos & grid_mask) != '0) ? base : base - step_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= 1'b0;
      cmd_q  <= 1'b0;
      pin_q  <= 1'b0;
      pos    <= HOME;
    end else begin
      pin_q <= step_pin;
      if (ctrl_wr) begin
        mode_q <= cfg_wdata[MODE_W-1:0];
        pol_q  <= cfg_wdata[MODE_W];
      end
      if (ctrl_wr && cfg_wdata[CMD_BIT] && !sleep) cmd_q <= 1'b1;
      else if (take_cmd || sleep)                  cmd_q <= 1'b0;
      if (pos_wr)    pos <= cfg_wdata[POS_W-1:0];
      else if (trig) pos <= next_pos;
    end
  end

  function automatic logic [POS_W-2:0] qidx(input logic [POS_W-1:0] p);
    logic [POS_W-2:0] r;
    r = {1'b0, p[QB-1:0]};
    return p[QB] ? (POS_W-1)'(QSPAN) - r : r;
  endfunction

  assign xp    = pos + POS_W'(QSPAN);
  assign y_idx = qidx(pos);
  assign x_idx = qidx(xp);
  assign y_neg = pos[POS_W-1] & (y_idx != '0);
  assign x_neg = xp[POS_W-1] & (x_idx != '0);

  assign cfg_rdata = cfg_sel ? DATA_W'(pos) : DATA_W'({cmd_q, pol_q, mode_q});
endmodule

// File: rtl/translator_checker.sv
module translator_checker #(
  parameter int POS_W  = 6,
  parameter int MODE_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              step_pin,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [POS_W-1:0]  pos,
  input logic              x_neg,
  input logic [POS_W-2:0]  x_idx,
  input logic              y_neg,
  input logic [POS_W-2:0]  y_idx,
  input logic              cmd_q,
  input logic              pin_q
);
  localparam int QB    = POS_W - 2;
  localparam int QSPAN = 1 << QB;
  localparam int CMD_BIT = MODE_W + 1;

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !(cfg_we && cfg_sel)) |=> $stable(pos));

  assert_write_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (pos == $past(cfg_wdata[POS_W-1:0])));

  assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && !sleep && !cfg_we && !(step_pin && !pin_q)) |=> !cmd_q);

  assert_no_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_pin && !cmd_q && !cfg_we) |=> $stable(pos));

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x_idx <= (POS_W-1)'(QSPAN)) && (y_idx <= (POS_W-1)'(QSPAN)));

  assert_zero_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_idx == '0) |-> !x_neg) and ((y_idx == '0) |-> !y_neg));

  assert_one_coil_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[QB-1:0] == '0) |-> ((x_idx == '0) != (y_idx == '0)));
endmodule

bind microstep_translator translator_checker #(
  .POS_W(POS_W), .MODE_W(MODE_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .step_pin(step_pin),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .pos(pos), .x_neg(x_neg), .x_idx(x_idx), .y_neg(y_neg), .y_idx(y_idx),
  .cmd_q(cmd_q), .pin_q(pin_q)
);

// File: tb/microstep_translator_test.sv
module microstep_translator_test;
  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, step_pin = 1'b0, dir_pin = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [5:0] pos;
  logic x_neg, y_neg;
  logic [4:0] x_idx, y_idx;

  microstep_translator uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .step_pin(step_pin), .dir_pin(dir_pin),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pos(pos), .x_neg(x_neg), .x_idx(x_idx), .y_neg(y_neg), .y_idx(y_idx)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int pos; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  int m_pos = 8, m_mode = 0;
  bit m_pol = 1'b0;

  function automatic int step_model(int p, int mode, bit f);
    int size;
    size = 1 << ((mode > 4) ? 4 : mode);
    if (f) return (((p / size) + 1) * size) % 64;
    if ((p % size) != 0) return (p / size) * size;
    return (p - size + 64) % 64;
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check_item(exp_t e);
    int pm, yi, xi;
    bit yn, xn;
    pm = e.pos % 32;
    yi = 16 - absv(pm - 16);
    xi = absv(pm - 16);
    yn = (e.pos > 32);
    xn = (e.pos > 16) && (e.pos < 48);
    checks++;
    if (int'(pos) != e.pos) begin
      fails++;
      $display("FAIL %s position: actual %0d expected %0d", e.tag, pos, e.pos);
    end
    checks++;
    if (int'(y_idx) != yi || y_neg != yn) begin
      fails++;
      $display("FAIL R9 coil Y at %0d: actual neg=%0d idx=%0d expected neg=%0d idx=%0d",
               e.pos, y_neg, y_idx, yn, yi);
    end
    checks++;
    if (int'(x_idx) != xi || x_neg != xn) begin
      fails++;
      $display("FAIL R10 coil X at %0d: actual neg=%0d idx=%0d expected neg=%0d idx=%0d",
               e.pos, x_neg, x_idx, xn, xi);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check_item(e);
    end
  end

  task automatic expect_pos(int d, string tag);
    q.push_back('{due: cyc + d, pos: m_pos, tag: tag});
  endtask

  task automatic check_rd(bit sel, int exp, string tag);
    cfg_sel = sel;
    #1;
    checks++;
    if (int'(cfg_rdata) != exp) begin
      fails++;
      $display("FAIL %s readback sel=%0d: actual %0d expected %0d", tag, sel, cfg_rdata, exp);
    end
    cfg_sel = 1'b0;
  endtask

  task automatic pin_step(bit d, string tag);
    dir_pin = d;
    step_pin = 1'b1;
    if (!sleep) m_pos = step_model(m_pos, m_mode, d ^ m_pol);
    expect_pos(1, tag);
    @(negedge clk);
    step_pin = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_ctrl(int mode, bit pol, bit cmd, string tag);
    cfg_we = 1'b1;
    cfg_sel = 1'b0;
    cfg_wdata = {3'b000, cmd, pol, mode[2:0]};
    m_mode = mode;
    m_pol = pol;
    if (cmd && !sleep) begin
      m_pos = step_model(m_pos, mode, dir_pin ^ pol);
      expect_pos(2, tag);
    end else expect_pos(1, tag);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_pos(int p, string tag);
    cfg_we = 1'b1;
    cfg_sel = 1'b1;
    cfg_wdata = 8'(p);
    m_pos = p;
    expect_pos(1, tag);
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_item('{due: cyc, pos: 8, tag: "R1"});
    check_rd(1'b0, 0, "R1");
    check_rd(1'b1, 8, "R12");

    pin_step(1'b1, "R2 R3 fine forward");
    pin_step(1'b0, "R3 fine backward");
    wr_ctrl(1, 1'b0, 1'b0, "R5 mode change holds position");
    check_rd(1'b0, 1, "R12");
    pin_step(1'b1, "R2 eighth step");
    wr_ctrl(2, 1'b0, 1'b0, "R5");
    pin_step(1'b1, "R2 quarter step");
    wr_ctrl(3, 1'b0, 1'b0, "R5");
    pin_step(1'b1, "R2 half step");
    wr_ctrl(4, 1'b0, 1'b0, "R5");
    pin_step(1'b1, "R2 full step");
    pin_step(1'b1, "R2 full step");
    pin_step(1'b1, "R3 wrap forward");
    pin_step(1'b0, "R3 wrap backward");
    wr_ctrl(7, 1'b0, 1'b0, "R5");
    pin_step(1'b1, "R2 reserved code as full");

    wr_ctrl(0, 1'b1, 1'b0, "R5 polarity");
    check_rd(1'b0, 8, "R12");
    pin_step(1'b1, "R3 inverted polarity backward");
    pin_step(1'b0, "R3 inverted polarity forward");

    wr_pos(9, "R7");
    wr_ctrl(4, 1'b0, 1'b0, "R5");
    pin_step(1'b1, "R6 snap up full");
    wr_pos(9, "R7");
    pin_step(1'b0, "R6 snap down full");
    wr_ctrl(2, 1'b0, 1'b0, "R5");
    wr_pos(22, "R7");
    pin_step(1'b1, "R6 snap up quarter");
    wr_pos(22, "R7");
    pin_step(1'b0, "R6 snap down quarter");
    wr_pos(37, "R7 write ignores mode");
    check_rd(1'b1, 37, "R12");

    dir_pin = 1'b1;
    wr_ctrl(0, 1'b0, 1'b1, "R4 command step");
    check_rd(1'b0, 0, "R4 command self-clear");

    dir_pin = 1'b1;
    step_pin = 1'b1;
    m_pos = step_model(m_pos, m_mode, 1'b1);
    expect_pos(1, "R4 pin edge");
    repeat (4) @(negedge clk);
    expect_pos(0, "R4 held pin single step");
    @(negedge clk);
    step_pin = 1'b0;
    @(negedge clk);

    wr_ctrl(3, 1'b0, 1'b1, "R5 mode and command together");

    sleep = 1'b1;
    @(negedge clk);
    pin_step(1'b1, "R8 pin ignored in sleep");
    wr_ctrl(3, 1'b0, 1'b1, "R8 command dropped in sleep");
    check_rd(1'b0, 3, "R8 no pending command");
    sleep = 1'b0;
    @(negedge clk);
    expect_pos(1, "R8 nothing after wake");
    @(negedge clk);
    @(negedge clk);

    cfg_we = 1'b1;
    cfg_sel = 1'b0;
    cfg_wdata = 8'b0001_0011;
    @(negedge clk);
    cfg_we = 1'b0;
    sleep = 1'b1;
    expect_pos(2, "R8 pending command discarded");
    @(negedge clk);
    @(negedge clk);
    sleep = 1'b0;
    check_rd(1'b0, 3, "R8 pending cleared");
    @(negedge clk);
    expect_pos(1, "R8 still held");
    @(negedge clk);
    @(negedge clk);

    wr_ctrl(0, 1'b0, 1'b0, "R5");
    dir_pin = 1'b1;
    step_pin = 1'b1;
    cfg_we = 1'b1;
    cfg_sel = 1'b0;
    cfg_wdata = 8'b0001_0000;
    m_pos = step_model(m_pos, 0, 1'b1);
    expect_pos(1, "R11 pin step first");
    m_pos = step_model(m_pos, 0, 1'b1);
    expect_pos(2, "R11 command step second");
    @(negedge clk);
    cfg_we = 1'b0;
    step_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);

    for (int p = 0; p < 64; p += 3) wr_pos(p, "R7 sweep R9 R10");
    wr_pos(16, "R10 grid");
    wr_pos(48, "R10 grid");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule